// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital sequencer of a 10-bit successive-approximation analog-to-digital converter. It sits behind a small byte-wide register interface. Software picks one of sixteen analog inputs and a reference arrangement, then writes a self-clearing start/busy bit. The block drives a trial code to an external DAC and comparator and resolves one result bit per conversion tick, from the most significant bit down. When it finishes it stores the code in a high/low result pair, drops the start/busy bit and raises a sticky interrupt flag.

The conversion tick comes either from a divided core tick (`conv_tick`) or from the converter's own RC oscillator tick (`rc_tick`). While `sleep` is high only the RC selection keeps the sequencer running, and register writes are dropped. A package parameter removes input channels. When software selects a missing channel, the block reports it as absent, and the analog mux then connects the negative reference.

All block I/O is plain control and status. No port carries a data stream, so no valid/ready handshake or back-pressure applies.

Top module: `sar_adc_ctrl`

## Requirements
- R1: With an ideal comparator (`comp_hi` = 1 when the input is at or above `dac_code`), the stored result equals the sampled input code for every value 0 to 1023.
- R2: Register map. Address 0 is control: bit0 enable, bit1 start/busy, bits5:2 channel. Address 1 is config: bits1:0 reference, bit2 RC clock select. Address 2 holds result bits 9:8 in bits 1:0, and its other bits read 0. Address 3 holds result bits 7:0. Address 4 holds the interrupt flag in bit0.
- R3: A write to address 0 with bits 1 and 0 both set starts a conversion. With a tick on every cycle, busy reads 1 for 10 edges after the write edge and clears at the 11th: one acquisition tick, then ten bit ticks.
- R4: The result load, the interrupt flag set and the start/busy clear all happen on the same clock edge.
- R5: The interrupt flag (`irq` and address 4 bit0) stays set until software writes address 4 with bit0 = 0.
- R6: While busy, a write to address 0 with the start bit set changes neither the running conversion, its finish time nor the channel field.
- R7: A start write with enable = 0 does nothing. Clearing enable during a conversion aborts it with no flag and no result write.
- R8: Reset aborts a running conversion and clears control, config and flag. It leaves the result pair unchanged.
- R9: While `sleep` = 1, register writes are ignored. With config bit2 = 0 the sequencer holds still. With bit2 = 1 it advances on `rc_tick` and completes.
- R10: With the smallest package (PKG=0), channels 5 and 12 to 15 report `an_present` = 0. The bench's ideal model then converts the negative reference, giving code 0.
- R11: Reference bit0 = 1 selects the external positive reference (`vref_pos_ext`), and bit1 = 1 selects the external negative reference (`vref_neg_ext`). A 0 in either bit selects the supply rail.
- R12: `sample_en` is high during the acquisition tick. The first bit tick sets `dac_code` to 512. `dac_code` changes only on a conversion tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Core asleep; writes dropped, core tick gated |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| conv_tick | input | 1 | Conversion tick derived from the core clock |
| rc_tick | input | 1 | Conversion tick from the internal RC oscillator |
| comp_hi | input | 1 | Comparator: input at or above trial code |
| dac_code | output | 10 | Trial code to the DAC |
| sample_en | output | 1 | Sample-and-hold tracking during acquisition |
| an_sel | output | 4 | Selected analog channel |
| an_present | output | 1 | Selected channel exists in this package |
| vref_pos_ext | output | 1 | Use external positive reference |
| vref_neg_ext | output | 1 | Use external negative reference |
| irq | output | 1 | Conversion-complete interrupt flag |

## Verification
The start write lands on edge E0. Acquisition ends at E1, and the last bit is resolved at E11, so busy, flag and result all change at E11. The bench holds the tick high, reads busy just after the falling edge that follows E10 and expects it high. It reads again after E11 and expects busy low, flag high and the result loaded. Register writes take effect on the edge inside the write task, and every read is sampled at the next falling edge. For the sleep and RC cases the tick spacing is irregular, so the bench polls busy with a bounded loop and then checks the result.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ACQ  = 2'd1,
    S_CONV = 2'd2
  } sar_state_e;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RESHI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RESLO = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd4;
endpackage

// File: rtl/sar_tick.sv
module sar_tick (
  input  logic sleep,
  input  logic use_rc,
  input  logic conv_tick,
  input  logic rc_tick,
  output logic adv
);
  // The core-derived tick stops with the core; the RC tick keeps running.
  always_comb begin
    if (use_rc) adv = rc_tick;
    else        adv = conv_tick & ~sleep;
  end
endmodule

// File: rtl/sar_chmux.sv
module sar_chmux #(
  parameter int CH_W = 4,
  parameter int PKG  = 2
) (
  input  logic [CH_W-1:0] ch,
  output logic [CH_W-1:0] an_sel,
  output logic            an_present
);
  localparam int N_CH = 1 << CH_W;

  logic [N_CH-1:0] avail;

  for (genvar i = 0; i < N_CH; i++) begin : g_avail
    if ((PKG == 0 && (i >= 12 || i == 5)) || (PKG == 1 && i == 5)) begin : g_gone
      assign avail[i] = 1'b0;
    end else begin : g_here
      assign avail[i] = 1'b1;
    end
  end

  assign an_sel     = ch;
  assign an_present = avail[ch];
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic             adv,
  input  logic             comp_hi,
  output logic             busy,
  output logic             acquire,
  output logic             done,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(RES_W - 1);

  sar_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] resolved;

  always_comb begin
    resolved      = trial;
    resolved[idx] = comp_hi;
  end

  assign busy    = (state != S_IDLE);
  assign acquire = (state == S_ACQ);
  assign done    = en && (state == S_CONV) && adv && (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      trial <= '0;
    end else if (start) begin
      state <= S_ACQ;
      idx   <= TOP;
      trial <= '0;
    end else if (!en) begin
      state <= S_IDLE;
      trial <= '0;
    end else begin
      case (state)
        S_ACQ: if (adv) begin
          state      <= S_CONV;
          trial      <= '0;
          trial[TOP] <= 1'b1;
          idx        <= TOP;
        end
        S_CONV: if (adv) begin
          if (idx == '0) begin
            state <= S_IDLE;
            trial <= '0;
          end else begin
            trial          <= resolved;
            trial[idx - 1] <= 1'b1;
            idx            <= idx - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Result pair has no reset: only a finished conversion writes it.
  always_ff @(posedge clk) begin
    if (done) result <= resolved;
  end

  a_r3_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r6_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  a_r7_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start) |=> !busy);
  a_r12_trial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && !adv && !start) |=> $stable(trial));
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CH_W   = 4,
  parameter int REF_W  = 2,
  parameter int RES_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [RES_W-1:0]  result,
  output logic              en,
  output logic [CH_W-1:0]   ch,
  output logic [REF_W-1:0]  refsel,
  output logic              use_rc,
  output logic              flag,
  output logic              start
);
  localparam int CH_LO = 2;
  localparam int CH_HI = CH_LO + CH_W - 1;
  localparam int RC_B  = REF_W;

  logic wr, wr_ctrl, wr_cfg, wr_flag;
  logic unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:CH_HI+1];

  assign wr      = we & ~sleep;
  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_cfg  = wr && (addr == A_CFG);
  assign wr_flag = wr && (addr == A_FLAG);
  assign start   = wr_ctrl && !busy && wdata[0] && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      ch     <= '0;
      refsel <= '0;
      use_rc <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en <= wdata[0];
        if (!busy) ch <= wdata[CH_HI:CH_LO];
      end
      if (wr_cfg) begin
        refsel <= wdata[REF_W-1:0];
        use_rc <= wdata[RC_B];
      end
      if (done)         flag <= 1'b1;
      else if (wr_flag) flag <= wdata[0];
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DATA_W'({ch, busy, en});
      A_CFG:   rdata = DATA_W'({use_rc, refsel});
      A_RESHI: rdata = DATA_W'(result[RES_W-1:DATA_W]);
      A_RESLO: rdata = result[DATA_W-1:0];
      A_FLAG:  rdata = DATA_W'(flag);
      default: rdata = '0;
    endcase
  end

  a_r4_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_flag) |=> flag);
  a_r9_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !busy) |=> $stable(ch) && $stable(refsel) && $stable(use_rc));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CH_W   = 4,
  parameter int REF_W  = 2,
  parameter int RES_W  = 10,
  parameter int PKG    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              conv_tick,
  input  logic              rc_tick,
  input  logic              comp_hi,
  output logic [RES_W-1:0]  dac_code,
  output logic              sample_en,
  output logic [CH_W-1:0]   an_sel,
  output logic              an_present,
  output logic              vref_pos_ext,
  output logic              vref_neg_ext,
  output logic              irq
);
  logic             en, use_rc, flag, start, busy, done, adv;
  logic [CH_W-1:0]  ch;
  logic [REF_W-1:0] refsel;
  logic [RES_W-1:0] result;

  sar_regs #(.DATA_W(DATA_W), .CH_W(CH_W), .REF_W(REF_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done(done),
    .result(result), .en(en), .ch(ch), .refsel(refsel), .use_rc(use_rc),
    .flag(flag), .start(start)
  );

  sar_tick u_tick (
    .sleep(sleep), .use_rc(use_rc), .conv_tick(conv_tick),
    .rc_tick(rc_tick), .adv(adv)
  );

  sar_seq #(.RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en), .adv(adv),
    .comp_hi(comp_hi), .busy(busy), .acquire(sample_en), .done(done),
    .trial(dac_code), .result(result)
  );

  sar_chmux #(.CH_W(CH_W), .PKG(PKG)) u_mux (
    .ch(ch), .an_sel(an_sel), .an_present(an_present)
  );

  assign vref_pos_ext = refsel[0];
  assign vref_neg_ext = refsel[REF_W-1];
  assign irq          = flag;

  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !use_rc && busy && en) |=> busy && $stable(dac_code));
  a_r12_acq_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (dac_code == '0));
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  localparam int PKG = 0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       conv_tick = 1'b1;
  logic       rc_tick = 1'b0;
  logic       rc_run = 1'b0;
  logic       comp_hi;
  logic [9:0] dac_code;
  logic       sample_en, an_present, vref_pos_ext, vref_neg_ext, irq;
  logic [3:0] an_sel;
  logic [9:0] vin [16];
  logic [9:0] model_vin;
  int         n_run = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  sar_adc_ctrl #(.PKG(PKG)) uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .conv_tick(conv_tick),
    .rc_tick(rc_tick), .comp_hi(comp_hi), .dac_code(dac_code),
    .sample_en(sample_en), .an_sel(an_sel), .an_present(an_present),
    .vref_pos_ext(vref_pos_ext), .vref_neg_ext(vref_neg_ext), .irq(irq)
  );

  // Ideal comparator; absent channel is tied to the negative reference.
  assign model_vin = an_present ? vin[an_sel] : 10'd0;
  assign comp_hi   = (model_vin >= dac_code);

  function automatic bit present(input int c);
    return !(PKG == 0 && (c >= 12 || c == 5)) && !(PKG == 1 && c == 5);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd_result(output int r);
    logic [7:0] hi, lo;
    rd(3'd2, hi);
    rd(3'd3, lo);
    r = {hi, lo};
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rd(3'd0, d);
      if (!d[1]) break;
    end
  endtask

  // Timed conversion with a tick on every cycle: done lands on edge E11.
  task automatic conv(input int c, input string tag);
    logic [7:0] d;
    int r, exp;
    exp = present(c) ? int'(vin[c]) : 0;
    wr(3'd0, 8'((c << 2) | 3));
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(3'd0, d);
    chk(d[1] == 1'b1, {tag, " R3 busy before E11"}, d[1], 1);
    @(posedge clk);
    @(negedge clk);
    rd(3'd0, d);
    chk(d[1] == 1'b0 && irq, {tag, " R4 done edge"}, {d[1], irq}, 1);
    rd_result(r);
    chk(r == exp, {tag, " R1/R2 result"}, r, exp);
    wr(3'd4, 8'h00);
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      rc_tick <= rc_run && (cnt % 3 == 0);
      cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int r;
    for (int i = 0; i < 16; i++) vin[i] = 10'((i * 67 + 13) % 1024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R8, R2)
    rd(3'd0, d); chk(d == 8'h00, "R8 ctrl after reset", d, 0);
    rd(3'd4, d); chk(d == 8'h00 && !irq, "R5 flag after reset", d, 0);
    chk(dac_code == 0 && !sample_en, "R12 idle outputs", dac_code, 0);

    // R1: exhaustive code sweep on channel 0
    for (int v = 0; v < 1024; v++) begin
      vin[0] = 10'(v);
      conv(0, "R1 sweep");
    end

    // R10: every channel under the small package
    for (int c = 0; c < 16; c++) begin
      vin[0] = 10'd77;
      conv(c, "R10 channel");
      chk(an_present == present(c), "R10 an_present", an_present, present(c));
    end

    // R2: upper bits of the high register read zero
    vin[0] = 10'd1023;
    conv(0, "R2 full scale");
    rd(3'd2, d); chk(d == 8'h03, "R2 high reg", d, 3);

    // R5: flag sticky until cleared
    vin[1] = 10'd400;
    wr(3'd0, 8'((1 << 2) | 3));
    wait_idle();
    repeat (5) @(negedge clk);
    rd(3'd4, d); chk(d[0] == 1'b1, "R5 flag holds", d[0], 1);
    wr(3'd4, 8'h00);
    rd(3'd4, d); chk(d[0] == 1'b0 && !irq, "R5 flag cleared", d[0], 0);

    // R12: acquisition then MSB trial
    vin[2] = 10'h2AA;
    wr(3'd0, 8'((2 << 2) | 3));
    chk(sample_en && dac_code == 0, "R12 acquire", sample_en, 1);
    @(posedge clk); @(negedge clk);
    chk(!sample_en && dac_code == 512, "R12 MSB trial", dac_code, 512);
    wait_idle();
    rd_result(r); chk(r == 'h2AA, "R12 result", r, 'h2AA);
    wr(3'd4, 8'h00);

    // R6: restart while busy is ignored
    vin[1] = 10'd321;
    wr(3'd0, 8'((1 << 2) | 3));
    repeat (2) @(negedge clk);
    wr(3'd0, 8'((2 << 2) | 3));
    repeat (6) @(posedge clk);
    @(negedge clk);
    rd(3'd0, d); chk(d[1] == 1'b1, "R6 still busy", d[1], 1);
    @(posedge clk); @(negedge clk);
    rd(3'd0, d); chk(d[1] == 1'b0, "R6 original finish time", d[1], 0);
    chk(d[5:2] == 4'd1, "R6 channel kept", d[5:2], 1);
    rd_result(r); chk(r == 321, "R6 result", r, 321);
    wr(3'd4, 8'h00);

    // R7: start with enable low, and abort by clearing enable
    wr(3'd0, 8'h02);
    rd(3'd0, d); chk(d[1] == 1'b0, "R7 no start when disabled", d[1], 0);
    vin[0] = 10'd900;
    wr(3'd0, 8'h03);
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h00);
    @(negedge clk);
    rd(3'd0, d); chk(d[1] == 1'b0, "R7 aborted", d[1], 0);
    repeat (15) @(negedge clk);
    rd(3'd4, d); chk(d[0] == 1'b0, "R7 no flag", d[0], 0);
    rd_result(r); chk(r == 321, "R7 result untouched", r, 321);

    // R11: reference selection
    wr(3'd1, 8'h01);
    chk(vref_pos_ext && !vref_neg_ext, "R11 ext positive", {vref_pos_ext, vref_neg_ext}, 2);
    wr(3'd1, 8'h02);
    chk(!vref_pos_ext && vref_neg_ext, "R11 ext negative", {vref_pos_ext, vref_neg_ext}, 1);
    wr(3'd1, 8'h00);

    // R9: core tick stalls during sleep; writes dropped
    vin[0] = 10'd600;
    wr(3'd0, 8'h03);
    sleep = 1'b1;
    repeat (30) @(negedge clk);
    rd(3'd0, d); chk(d[1] == 1'b1 && dac_code == 0, "R9 held in sleep", d[1], 1);
    wr(3'd1, 8'h03);
    rd(3'd1, d); chk(d == 8'h00, "R9 write ignored", d, 0);
    sleep = 1'b0;
    wait_idle();
    rd_result(r); chk(r == 600, "R9 resume result", r, 600);
    wr(3'd4, 8'h00);

    // R9: RC tick converts during sleep
    wr(3'd1, 8'h04);
    conv_tick = 1'b0;
    rc_run = 1'b1;
    vin[3] = 10'd555;
    wr(3'd0, 8'((3 << 2) | 3));
    sleep = 1'b1;
    wait_idle();
    sleep = 1'b0;
    rd_result(r); chk(r == 555, "R9 rc result", r, 555);
    rd(3'd4, d); chk(d[0] == 1'b1, "R9 rc flag", d[0], 1);
    rc_run = 1'b0;
    conv_tick = 1'b1;
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h00);

    // R8: reset mid-conversion keeps old result
    vin[0] = 10'd300;
    conv(0, "R8 setup");
    vin[0] = 10'd700;
    wr(3'd0, 8'h03);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (15) @(negedge clk);
    rd(3'd0, d); chk(d == 8'h00, "R8 aborted ctrl", d, 0);
    rd(3'd4, d); chk(d == 8'h00, "R8 flag clear", d, 0);
    rd_result(r); chk(r == 300, "R8 result kept", r, 300);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule